// File: doc/BRIEF.md
# Two-Axis Accelerometer Register Slave on I2C

This block is an I2C target that presents the register view of a two-axis acceleration sensor. An external master reaches it over SCL and SDA. The block never drives SCL. It pulls SDA low through an open-drain enable output and reads the resolved line back on an input. X, Y and temperature samples arrive on parallel ports and are captured on a strobe. Each captured sample keeps only its `SAMPLE_BITS` low bits, and the upper bits read as zero.

The master writes a one-byte pointer, and an optional second byte lands in the single control register at position 0. Bit 0 of that register drives the power-down level. Bit 1 drives the temperature-select level. A read burst starts at the current pointer. It walks positions 0 through 6, then returns to 0. While temperature-select is set, the temperature bytes replace the X bytes. All sample bytes of a burst are frozen when the read address is accepted, so each high/low byte pair comes from a single sample.

Top module: `accel_i2c_regs`

## Requirements
- R1: The block acknowledges only the 7-bit address {0010, addr_strap}. It does not acknowledge any other address, and it then leaves SDA released and the control register unchanged until the next START.
- R2: The first data byte of a write loads the pointer from its low 3 bits, and a value of 7 loads 0. Each further byte is stored in the control register only when the pointer is 0, is otherwise discarded, and advances the pointer. Every written byte is acknowledged.
- R3: The control register resets to 0x00. pwr_down equals control bit 0 and temp_sel equals control bit 1, and both change only while SCL is low.
- R4: Read positions return, in order: 0 control, 1 X high byte, 2 X low byte, 3 Y high byte, 4 Y low byte, 5 and 6 both 0x00. After each byte the pointer advances, and after position 6 it wraps to 0.
- R5: A read burst begins at the pointer left by the previous write.
- R6: While control bit 1 is 1, positions 1 and 2 return the temperature high and low bytes instead of X.
- R7: A captured sample has bits at and above SAMPLE_BITS (default 12) forced to zero.
- R8: Sample values are frozen when a read address is acknowledged. A strobe during the burst changes nothing until the next burst.
- R9: A master NACK after a read byte ends the burst. SDA stays released through any further SCL pulses until the next START.
- R10: A STOP at any point returns the block to idle with SDA released. An unfinished write byte is discarded.
- R11: SDA is released after reset and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Resolved bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 3 | Low three bits of the bus address |
| sample_stb | input | 1 | Captures the three sample inputs |
| x_sample | input | 16 | X acceleration sample |
| y_sample | input | 16 | Y acceleration sample |
| t_sample | input | 16 | Temperature sample |
| pwr_down | output | 1 | Power-down level (control bit 0) |
| temp_sel | output | 1 | Temperature-select level (control bit 1) |

## Verification
Read bursts are tried with X samples that carry set bits above the resolution. This shows masking apart from a plain byte pass-through. The bursts also run past position 6, which shows the zero padding and the wrap-around. Bursts are started at pointer 0, at pointer 1 and at pointer 7. These three starts show apart a correct pointer load, a pointer fixed at 0 and the treatment of 7 as 0.

Writes cover the control register, a read-only position and a stream cut short by STOP. Together they show that only position 0 takes data and that a partial byte is dropped. A strobe in the middle of a burst shows whether samples are frozen at the address phase or read live. Addresses that differ in the strap bits or in the fixed bits show that all seven bits are compared.

// File: rtl/accel_i2c_regs.sv
`timescale 1ns/1ps
module accel_i2c_regs #(
  parameter logic [3:0] ADDR_HI = 4'b0010,
  parameter int SAMPLE_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  addr_strap,
  input  logic        sample_stb,
  input  logic [15:0] x_sample,
  input  logic [15:0] y_sample,
  input  logic [15:0] t_sample,
  output logic        pwr_down,
  output logic        temp_sel
);
  localparam logic [15:0] KEEP = 16'((32'd1 << SAMPLE_BITS) - 32'd1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK} st_t;

  st_t         st;
  logic        scl_m, scl_s, scl_d, sda_m, sda_s, sda_d;
  logic [3:0]  cnt;
  logic [7:0]  shr, tx, ctrl, rd_byte;
  logic [2:0]  ptr, ptr_nx;
  logic        rw, first, mack;
  logic [15:0] hold_x, hold_y, hold_t, snap_x, snap_y, snap_t;
  logic        scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, scl_d, sda_m, sda_s, sda_d} <= '1;
    else {scl_m, scl_s, scl_d, sda_m, sda_s, sda_d} <= {scl_i, scl_m, scl_s, sda_i, sda_m, sda_s};

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign ptr_nx    = (ptr == 3'd6) ? 3'd0 : ptr + 3'd1;
  assign pwr_down  = ctrl[0];
  assign temp_sel  = ctrl[1];

  always_comb
    case (ptr)
      3'd0:    rd_byte = ctrl;
      3'd1:    rd_byte = ctrl[1] ? snap_t[15:8] : snap_x[15:8];
      3'd2:    rd_byte = ctrl[1] ? snap_t[7:0]  : snap_x[7:0];
      3'd3:    rd_byte = snap_y[15:8];
      3'd4:    rd_byte = snap_y[7:0];
      default: rd_byte = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; shr <= '0; tx <= '0; ctrl <= '0; ptr <= '0;
      rw <= 1'b0; first <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      hold_x <= '0; hold_y <= '0; hold_t <= '0;
      snap_x <= '0; snap_y <= '0; snap_t <= '0;
    end else begin
      if (sample_stb) begin
        hold_x <= x_sample & KEEP;
        hold_y <= y_sample & KEEP;
        hold_t <= t_sample & KEEP;
      end
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          ST_ADDR, ST_WR: begin shr <= {shr[6:0], sda_s}; cnt <= cnt + 4'd1; end
          ST_RD:          cnt <= cnt + 4'd1;
          ST_RACK:        mack <= ~sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ST_ADDR:
            if (cnt == 4'd8) begin
              if (shr[7:1] == {ADDR_HI, addr_strap}) begin
                st <= ST_AACK; sda_oe <= 1'b1; rw <= shr[0];
                if (shr[0]) begin snap_x <= hold_x; snap_y <= hold_y; snap_t <= hold_t; end
              end else st <= ST_IDLE;
            end
          ST_AACK: begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_byte; sda_oe <= ~rd_byte[7]; ptr <= ptr_nx; st <= ST_RD;
            end else begin
              sda_oe <= 1'b0; first <= 1'b1; st <= ST_WR;
            end
          end
          ST_WR:
            if (cnt == 4'd8) begin
              sda_oe <= 1'b1; st <= ST_WACK; first <= 1'b0;
              if (first) ptr <= (shr[2:0] == 3'd7) ? 3'd0 : shr[2:0];
              else begin
                if (ptr == 3'd0) ctrl <= shr;
                ptr <= ptr_nx;
              end
            end
          ST_WACK: begin sda_oe <= 1'b0; cnt <= '0; st <= ST_WR; end
          ST_RD:
            if (cnt == 4'd8) begin sda_oe <= 1'b0; st <= ST_RACK; end
            else begin tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; end
          ST_RACK: begin
            cnt <= '0;
            if (mack) begin
              tx <= rd_byte; sda_oe <= ~rd_byte[7]; ptr <= ptr_nx; st <= ST_RD;
            end else st <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module accel_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       pwr_down,
  input logic       temp_sel,
  input logic       start_det,
  input logic       stop_det,
  input logic       idle,
  input logic [2:0] ptr
);
  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (idle && !sda_oe));
  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  // R11
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R3
  ctrl_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pwr_down, temp_sel}) |-> !scl_s);
  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != 3'd7);
endmodule

bind accel_i2c_regs accel_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .pwr_down(pwr_down), .temp_sel(temp_sel), .start_det(start_det),
  .stop_det(stop_det), .idle(st == ST_IDLE), .ptr(ptr)
);

// File: tb/accel_i2c_regs_tb.sv
`timescale 1ns/1ps
module accel_i2c_regs_tb;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV = {4'b0010, STRAP};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, m_scl = 1'b1, m_low = 1'b0, stb = 1'b0;
  logic [15:0] xs = '0, ys = '0, ts = '0;
  logic sda_oe, pwr_down, temp_sel, sda_bus, done = 1'b0;
  int checks = 0, bad = 0;

  assign sda_bus = ~(m_low | sda_oe);

  accel_i2c_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(STRAP), .sample_stb(stb), .x_sample(xs), .y_sample(ys),
    .t_sample(ts), .pwr_down(pwr_down), .temp_sel(temp_sel)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i_start;
    m_low = 1'b0; m_scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic i_stop;
    m_low = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic sbit(input logic b);
    m_low = ~b; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    m_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q/2); ack = ~sda_bus;
    tick(Q/2); m_scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q/2); d[i] = sda_bus;
      tick(Q/2); m_scl = 1'b0; tick(Q);
    end
    sbit(~ack);
  endtask

  task automatic wr_txn(input logic [7:0] p, input bit has_data, input logic [7:0] d);
    logic a;
    i_start; wbyte({DEV, 1'b0}, a); wbyte(p, a);
    if (has_data) wbyte(d, a);
    i_stop;
  endtask

  task automatic rd_expect(input int n, input logic [7:0] exp [], input string tag);
    logic a;
    logic [7:0] d;
    i_start; wbyte({DEV, 1'b1}, a);
    check(a, {tag, " read address ack"}, 16'(a), 16'd1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      check(d == exp[i], $sformatf("%s byte %0d", tag, i), 16'(d), 16'(exp[i]));
    end
    i_stop;
  endtask

  task automatic load(input logic [15:0] x, input logic [15:0] y, input logic [15:0] t);
    xs = x; ys = y; ts = t; stb = 1'b1; tick(1); stb = 1'b0; tick(1);
  endtask

  task automatic t_reset;
    check(pwr_down == 1'b0, "R3 reset pwr_down", 16'(pwr_down), 16'd0);
    check(temp_sel == 1'b0, "R3 reset temp_sel", 16'(temp_sel), 16'd0);
    check(sda_oe == 1'b0, "R11 reset sda released", 16'(sda_oe), 16'd0);
  endtask

  task automatic t_addr;
    logic a;
    logic seen;
    i_start; wbyte({4'b0010, 3'b100, 1'b0}, a);
    check(!a, "R1 strap mismatch nack", 16'(a), 16'd0);
    seen = 1'b0;
    wbyte(8'h00, a); seen |= a; wbyte(8'h01, a); seen |= a;
    check(!seen, "R1 ignored after mismatch", 16'(seen), 16'd0);
    i_stop;
    check(pwr_down == 1'b0, "R1 ctrl untouched", 16'(pwr_down), 16'd0);
    i_start; wbyte({4'b0110, STRAP, 1'b0}, a);
    check(!a, "R1 upper bits mismatch nack", 16'(a), 16'd0);
    i_stop;
    i_start; wbyte({DEV, 1'b0}, a);
    check(a, "R1 matching address ack", 16'(a), 16'd1);
    wbyte(8'h00, a);
    check(a, "R2 pointer byte ack", 16'(a), 16'd1);
    i_stop;
  endtask

  task automatic t_ctrl;
    logic [7:0] e [];
    wr_txn(8'h00, 1, 8'h01);
    check(pwr_down == 1'b1, "R3 pwr_down set", 16'(pwr_down), 16'd1);
    wr_txn(8'h00, 1, 8'h00);
    check(pwr_down == 1'b0, "R3 pwr_down cleared", 16'(pwr_down), 16'd0);
    wr_txn(8'h03, 1, 8'hFF);
    check(pwr_down == 1'b0 && temp_sel == 1'b0, "R2 write at position 3 ignored",
          16'({temp_sel, pwr_down}), 16'd0);
    wr_txn(8'h07, 0, 8'h00);
    e = new[1]; e[0] = 8'h00;
    rd_expect(1, e, "R2 pointer 7 loads 0");
  endtask

  task automatic t_burst;
    logic [7:0] e [];
    load(16'hFABC, 16'h7123, 16'h0456);
    wr_txn(8'h00, 0, 8'h00);
    e = new[9];
    e = '{8'h00, 8'h0A, 8'hBC, 8'h01, 8'h23, 8'h00, 8'h00, 8'h00, 8'h0A};
    rd_expect(9, e, "R4 R7 burst with wrap");
    wr_txn(8'h01, 0, 8'h00);
    e = new[2]; e = '{8'h0A, 8'hBC};
    rd_expect(2, e, "R5 start at pointer 1");
  endtask

  task automatic t_temp;
    logic [7:0] e [];
    wr_txn(8'h00, 1, 8'h02);
    check(temp_sel == 1'b1, "R3 temp_sel set", 16'(temp_sel), 16'd1);
    wr_txn(8'h00, 0, 8'h00);
    e = new[5]; e = '{8'h02, 8'h04, 8'h56, 8'h01, 8'h23};
    rd_expect(5, e, "R6 temperature replaces X");
    wr_txn(8'h00, 1, 8'h00);
  endtask

  task automatic t_snap;
    logic a;
    logic [7:0] d;
    load(16'h0111, 16'h0222, 16'h0333);
    wr_txn(8'h01, 0, 8'h00);
    i_start; wbyte({DEV, 1'b1}, a);
    rbyte(1'b1, d);
    check(d == 8'h01, "R8 first byte", 16'(d), 16'h01);
    load(16'h0999, 16'h0888, 16'h0777);
    rbyte(1'b1, d);
    check(d == 8'h11, "R8 X low frozen", 16'(d), 16'h11);
    rbyte(1'b0, d);
    check(d == 8'h02, "R8 Y high frozen", 16'(d), 16'h02);
    i_stop;
    wr_txn(8'h01, 0, 8'h00);
    i_start; wbyte({DEV, 1'b1}, a); rbyte(1'b0, d); i_stop;
    check(d == 8'h09, "R8 next burst sees new sample", 16'(d), 16'h09);
  endtask

  task automatic t_nack;
    logic a;
    logic [7:0] d;
    wr_txn(8'h03, 0, 8'h00);
    i_start; wbyte({DEV, 1'b1}, a);
    rbyte(1'b0, d);
    check(d == 8'h08, "R9 byte before nack", 16'(d), 16'h08);
    rbyte(1'b0, d);
    check(d == 8'hFF, "R9 sda released after nack", 16'(d), 16'hFF);
    i_stop;
    check(sda_oe == 1'b0, "R9 idle after stop", 16'(sda_oe), 16'd0);
  endtask

  task automatic t_stop_mid;
    logic a;
    logic [7:0] e [];
    i_start; wbyte({DEV, 1'b0}, a); wbyte(8'h00, a);
    sbit(1'b0); sbit(1'b0); sbit(1'b0); sbit(1'b0);
    i_stop;
    check(sda_oe == 1'b0, "R10 released after early stop", 16'(sda_oe), 16'd0);
    check(pwr_down == 1'b0, "R10 partial byte dropped", 16'(pwr_down), 16'd0);
    wr_txn(8'h00, 0, 8'h00);
    e = new[1]; e[0] = 8'h00;
    rd_expect(1, e, "R10 bus usable after early stop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_addr;
    t_ctrl;
    t_burst;
    t_temp;
    t_snap;
    t_nack;
    t_stop_mid;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule